// File: doc/BRIEF.md
# Tagged Fixnum Arithmetic Unit

This unit executes one arithmetic instruction per cycle on tagged 64-bit words. Each word is either an inline signed integer or a reference to a number kept elsewhere, and its lowest bit says which. For every issued instruction the unit checks both tags, computes the sum, difference or product of the inline integers, and tests whether the exact result still fits the inline integer width. When all of this succeeds, the unit returns a re-tagged inline result.

The unit can also leave the fast path. This happens when an operand is a reference or the result does not fit. In that case the unit writes no result. It raises a redirect instead, which carries a handler address and a cause code. The address comes from a small handler table that software fills through a configuration write port. The table holds one entry for each opcode in each of two modes. Mode 0 selects the promotion-to-big-number handlers and mode 1 selects the trap handlers. The two modes differ only in which table entry is read.

The unit has one cycle of latency. An instruction sampled on a rising clock edge presents its outcome on the outputs just after that edge.

Top module: `tfx_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` and `out_redirect` are low. Every handler table entry resets to address 0.
- R2: A word with bit 0 = 0 is an inline integer whose signed value sits in bits 63:1. A word with bit 0 = 1 is a reference. A fast-path result has bit 0 = 0, the value in bits 63:1, `out_redirect` = 0 and `out_cause` = 0.
- R3: Opcode 0 adds, 1 subtracts (left minus right) and 2 multiplies. When the exact result lies in [-2^62, 2^62-1], it is returned one cycle after issue.
- R4: When both operands are inline and the exact result falls outside that range, the unit sets `out_redirect` = 1 with cause 3, drives `out_result` to 0, and drives `out_target` from the table entry for that opcode and mode.
- R5: A reference in the left operand gives cause 1. A reference only in the right operand gives cause 2. The left-operand cause wins over the right-operand cause, and either reference cause wins over overflow.
- R6: The table index is {mode, opcode}. Mode 0 reads entries 0..2 and mode 1 reads entries 4..6.
- R7: A configuration write updates its entry at the clock edge. An instruction issued in the same cycle as the write still sees the old entry. Later instructions see the new one.
- R8: A cycle with `in_valid` low, or with opcode 3, produces no output: `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 2 | Opcode: 0 add, 1 sub, 2 mul, 3 reserved |
| in_mode | input | 1 | 0 promote to big number, 1 trap |
| in_a | input | 64 | Left tagged operand |
| in_b | input | 64 | Right tagged operand |
| cfg_we | input | 1 | Handler table write enable |
| cfg_idx | input | 3 | Table entry index {mode, opcode} |
| cfg_target | input | TGT_W (48) | Handler address to store |
| out_valid | output | 1 | Outcome of an issued instruction |
| out_redirect | output | 1 | Slow path taken, no result written |
| out_cause | output | 2 | 0 none, 1 left reference, 2 right reference, 3 overflow |
| out_target | output | TGT_W (48) | Handler address when redirecting, else 0 |
| out_result | output | 64 | Tagged inline result on the fast path, else 0 |

## Verification
Two functions can fall in the same cycle: a handler table write and an instruction whose redirect reads that same entry. The bench provokes this with directed cases that write an entry while an overflowing or reference-carrying instruction for that entry is issued. It repeats this in the random phase, where table writes land on random entries alongside random instructions. The bench judges each outcome against its own shadow copy of the table, and it updates that copy only after the instruction's expected outcome has been taken. So the colliding instruction must report the old address and the following one must report the new address.

// File: rtl/tfx_pkg.sv
package tfx_pkg;

    localparam int VAL_W  = 64;
    localparam int INT_W  = VAL_W - 1;
    localparam int OP_W   = 2;
    localparam int MODE_W = 1;
    localparam int IDX_W  = MODE_W + OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_RSV = 2'd3
    } tfx_op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_LPTR = 2'd1,
        CAUSE_RPTR = 2'd2,
        CAUSE_OVF  = 2'd3
    } tfx_cause_e;

    // bit 0 is the tag, the number sits above it
    typedef struct packed {
        logic [INT_W-1:0] num;
        logic             is_ref;
    } tfx_word_t;

    function automatic logic op_supported(input logic [OP_W-1:0] op);
        return op != OP_RSV;
    endfunction

    // reference causes outrank overflow, left outranks right
    function automatic tfx_cause_e pick_cause(input logic lref,
                                              input logic rref,
                                              input logic ovf);
        if (lref)      return CAUSE_LPTR;
        else if (rref) return CAUSE_RPTR;
        else if (ovf)  return CAUSE_OVF;
        else           return CAUSE_NONE;
    endfunction

endpackage

// File: rtl/tfx_alu.sv
module tfx_alu
    import tfx_pkg::*;
#(
    parameter int NW = INT_W
) (
    input  logic [NW-1:0] a,
    input  logic [NW-1:0] b,
    input  tfx_op_e       op,
    output logic [NW-1:0] res,
    output logic          ovf
);
    localparam int WIDE_W = 2 * NW;

    logic [NW:0]       sum_w;
    logic [NW:0]       dif_w;
    logic [WIDE_W-1:0] a_x;
    logic [WIDE_W-1:0] b_x;
    logic [WIDE_W-1:0] prod_w;
    logic [WIDE_W-NW:0] prod_hi;

    always_comb begin
        sum_w   = {a[NW-1], a} + {b[NW-1], b};
        dif_w   = {a[NW-1], a} - {b[NW-1], b};
        a_x     = {{NW{a[NW-1]}}, a};
        b_x     = {{NW{b[NW-1]}}, b};
        prod_w  = a_x * b_x;
        prod_hi = prod_w[WIDE_W-1:NW-1];
        unique case (op)
            OP_ADD: begin
                res = sum_w[NW-1:0];
                ovf = sum_w[NW] ^ sum_w[NW-1];
            end
            OP_SUB: begin
                res = dif_w[NW-1:0];
                ovf = dif_w[NW] ^ dif_w[NW-1];
            end
            OP_MUL: begin
                res = prod_w[NW-1:0];
                ovf = !((&prod_hi) || !(|prod_hi));
            end
            default: begin
                res = '0;
                ovf = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tfx_handler_table.sv
module tfx_handler_table
    import tfx_pkg::*;
#(
    parameter int TGT_W = 48,
    parameter int IW    = IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [TGT_W-1:0] wr_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [TGT_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IW;

    logic [TGT_W-1:0] slot [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[e] <= '0;
            else if (wr_en && wr_idx == IW'(e))
                slot[e] <= wr_data;
        end
    end

    // read is combinational on the pre-write contents
    assign rd_data = slot[rd_idx];

    // R7
    table_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slot[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/tfx_unit.sv
module tfx_unit
    import tfx_pkg::*;
#(
    parameter int TGT_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic              in_mode,
    input  logic [63:0]       in_a,
    input  logic [63:0]       in_b,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_idx,
    input  logic [TGT_W-1:0]  cfg_target,
    output logic              out_valid,
    output logic              out_redirect,
    output logic [1:0]        out_cause,
    output logic [TGT_W-1:0]  out_target,
    output logic [63:0]       out_result
);
    tfx_word_t        opa, opb, fast_word;
    tfx_op_e          op;
    tfx_cause_e       cause_n;
    logic             issue, ovf, slow;
    logic [INT_W-1:0] fast_num;
    logic [TGT_W-1:0] hdl_addr;

    assign opa   = tfx_word_t'(in_a);
    assign opb   = tfx_word_t'(in_b);
    assign op    = tfx_op_e'(in_op);
    assign issue = in_valid && op_supported(in_op);

    tfx_alu #(.NW(INT_W)) i_alu (
        .a   (opa.num),
        .b   (opb.num),
        .op  (op),
        .res (fast_num),
        .ovf (ovf)
    );

    tfx_handler_table #(.TGT_W(TGT_W), .IW(IDX_W)) i_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_target),
        .rd_idx  ({in_mode, in_op}),
        .rd_data (hdl_addr)
    );

    assign cause_n   = pick_cause(opa.is_ref, opb.is_ref, ovf);
    assign slow      = cause_n != CAUSE_NONE;
    assign fast_word = '{num: fast_num, is_ref: 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_redirect <= 1'b0;
            out_cause    <= CAUSE_NONE;
            out_target   <= '0;
            out_result   <= '0;
        end else begin
            out_valid    <= issue;
            out_redirect <= issue && slow;
            out_cause    <= issue ? cause_n : CAUSE_NONE;
            out_target   <= (issue && slow) ? hdl_addr : '0;
            out_result   <= (issue && !slow) ? fast_word : '0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !out_valid && !out_redirect);

    // R2
    fast_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_redirect) |-> (out_result[0] == 1'b0 && out_cause == CAUSE_NONE));

    // R4
    redirect_no_result_chk: assert property (@(posedge clk) disable iff (rst)
        out_redirect |-> (out_valid && out_result == '0 && out_cause != CAUSE_NONE));

    // R5
    left_ref_first_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op != 2'd3 && in_a[0]) |=> (out_redirect && out_cause == CAUSE_LPTR));

    // R8
    reserved_op_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd3) |=> !out_valid);
endmodule

// File: tb/test_tfx_unit.sv
module test_tfx_unit;
    localparam int TGT_W = 48;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [1:0]       in_op = '0;
    logic             in_mode = 1'b0;
    logic [63:0]      in_a = '0, in_b = '0;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_idx = '0;
    logic [TGT_W-1:0] cfg_target = '0;
    logic             out_valid, out_redirect;
    logic [1:0]       out_cause;
    logic [TGT_W-1:0] out_target;
    logic [63:0]      out_result;

    int checks = 0;
    int errors = 0;
    logic [TGT_W-1:0] shadow [8];

    always #2ns clk = ~clk;

    tfx_unit #(.TGT_W(TGT_W)) i_tfx_unit (.*);

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic signed [62:0] v);
        return {v, 1'b0};
    endfunction

    // exact arithmetic on 128 bits, range test against the inline width
    task automatic model(input logic [1:0] op, input logic mode,
                         input logic [63:0] a, input logic [63:0] b,
                         output logic valid, output logic redir,
                         output logic [1:0] cause, output logic [TGT_W-1:0] tgt,
                         output logic [63:0] res);
        logic signed [127:0] ea, eb, r, lim;
        logic ov;
        ea  = {{65{a[63]}}, a[63:1]};
        eb  = {{65{b[63]}}, b[63:1]};
        lim = 128'sd1 <<< 62;
        case (op)
            2'd0: r = ea + eb;
            2'd1: r = ea - eb;
            default: r = ea * eb;
        endcase
        ov    = (r >= lim) || (r < -lim);
        valid = in_valid_model(op);
        cause = a[0] ? 2'd1 : b[0] ? 2'd2 : ov ? 2'd3 : 2'd0;
        redir = valid && cause != 2'd0;
        if (!valid) cause = 2'd0;
        tgt   = redir ? shadow[{mode, op}] : '0;
        res   = (valid && !redir) ? {r[62:0], 1'b0} : 64'd0;
    endtask

    function automatic logic in_valid_model(input logic [1:0] op);
        return op != 2'd3;
    endfunction

    task automatic issue(input logic [1:0] op, input logic mode,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic wr, input logic [2:0] wi,
                         input logic [TGT_W-1:0] wt, input string req);
        logic ev, er;
        logic [1:0] ec;
        logic [TGT_W-1:0] et;
        logic [63:0] eres;
        model(op, mode, a, b, ev, er, ec, et, eres);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_mode = mode; in_a = a; in_b = b;
        cfg_we = wr; cfg_idx = wi; cfg_target = wt;
        @(posedge clk); #1;
        in_valid = 1'b0; cfg_we = 1'b0;
        if (wr) shadow[wi] = wt;
        chk({req, " valid"},    128'(out_valid),    128'(ev));
        chk({req, " redirect"}, 128'(out_redirect), 128'(er));
        chk({req, " cause"},    128'(out_cause),    128'(ec));
        chk({req, " target"},   128'(out_target),   128'(et));
        chk({req, " result"},   128'(out_result),   128'(eres));
    endtask

    task automatic cfg_write(input logic [2:0] wi, input logic [TGT_W-1:0] wt);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = wi; cfg_target = wt;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        shadow[wi] = wt;
    endtask

    function automatic logic [63:0] rnd_word();
        logic [63:0] w;
        int sel;
        sel = int'($urandom % 8);
        w = {$urandom, $urandom};
        if (sel == 0)      return {w[63:1], 1'b1};
        else if (sel < 3)  return {w[63:1], 1'b0};
        else               return mk(63'(signed'(w[20:0]) - 21'sd0) - 63'sd1048576);
    endfunction

    localparam logic signed [62:0] MAXV = {1'b0, {62{1'b1}}};
    localparam logic signed [62:0] MINV = {1'b1, {62{1'b0}}};

    initial begin
        void'($urandom(32'h7a11_5eed));
        for (int i = 0; i < 8; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 during reset
        chk("R1 valid in reset", 128'(out_valid), 128'(0));
        chk("R1 redirect in reset", 128'(out_redirect), 128'(0));
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 valid after reset", 128'(out_valid), 128'(0));
        // R1 entries reset to zero: reference redirect reports address 0
        issue(2'd0, 1'b0, 64'd1, mk(63'sd5), 1'b0, 3'd0, '0, "R1 table reset");

        for (int i = 0; i < 8; i++) cfg_write(3'(i), TGT_W'(48'h1000 + i * 48'h10));

        // R2 R3 directed fast path
        issue(2'd0, 1'b0, mk(63'sd7), mk(-63'sd9), 1'b0, 3'd0, '0, "R3 add");
        issue(2'd1, 1'b0, mk(-63'sd100), mk(63'sd23), 1'b0, 3'd0, '0, "R3 sub");
        issue(2'd2, 1'b1, mk(-63'sd1234), mk(63'sd5678), 1'b0, 3'd0, '0, "R2 mul tag");
        issue(2'd0, 1'b0, mk(MAXV), mk(63'sd0), 1'b0, 3'd0, '0, "R3 add edge max");
        issue(2'd1, 1'b0, mk(MINV + 63'sd1), mk(63'sd1), 1'b0, 3'd0, '0, "R3 sub edge min");
        // R4 overflow boundaries
        issue(2'd0, 1'b0, mk(MAXV), mk(63'sd1), 1'b0, 3'd0, '0, "R4 add overflow");
        issue(2'd1, 1'b1, mk(MINV), mk(63'sd1), 1'b0, 3'd0, '0, "R4 sub overflow");
        issue(2'd2, 1'b0, mk(MINV), mk(-63'sd1), 1'b0, 3'd0, '0, "R4 mul min by -1");
        issue(2'd2, 1'b1, mk(63'sd1 <<< 31), mk(63'sd1 <<< 31), 1'b0, 3'd0, '0, "R4 mul 2^62");
        issue(2'd2, 1'b0, mk(-(63'sd1 <<< 31)), mk(63'sd1 <<< 31), 1'b0, 3'd0, '0, "R3 mul -2^62 fits");
        // R5 priorities
        issue(2'd0, 1'b0, 64'hF, 64'h3, 1'b0, 3'd0, '0, "R5 both refs left wins");
        issue(2'd1, 1'b1, mk(63'sd4), 64'h81, 1'b0, 3'd0, '0, "R5 right ref");
        issue(2'd0, 1'b0, {MAXV, 1'b1}, mk(MAXV), 1'b0, 3'd0, '0, "R5 ref over overflow");
        // R6 mode selects entry
        issue(2'd2, 1'b0, 64'h1, 64'h0, 1'b0, 3'd0, '0, "R6 mode0 mul entry");
        issue(2'd2, 1'b1, 64'h1, 64'h0, 1'b0, 3'd0, '0, "R6 mode1 mul entry");
        // R7 write in same cycle as a redirect reading that entry
        issue(2'd0, 1'b1, 64'h1, 64'h0, 1'b1, 3'd4, 48'hABCD_0000_1111, "R7 same cycle old entry");
        issue(2'd0, 1'b1, 64'h1, 64'h0, 1'b0, 3'd0, '0, "R7 next op new entry");
        // R8 reserved opcode and idle
        issue(2'd3, 1'b0, mk(63'sd1), mk(63'sd2), 1'b0, 3'd0, '0, "R8 reserved op");
        @(negedge clk);
        in_valid = 1'b0; in_op = 2'd0; in_a = 64'h1; in_b = 64'h1;
        @(posedge clk); #1;
        chk("R8 idle no output", 128'(out_valid), 128'(0));

        // random phase with occasional colliding table writes
        for (int n = 0; n < 600; n++) begin
            logic [1:0] op;
            logic wr;
            op = 2'($urandom % 4);
            wr = ($urandom % 6) == 0;
            issue(op, 1'($urandom), rnd_word(), rnd_word(), wr,
                  3'($urandom), TGT_W'({$urandom, $urandom}), "R3 R4 R5 R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule